// File: doc/BRIEF.md
# Periodic Interval Timer with Two-Phase Interrupt Retirement

This block is a bus-attached interval timer for a 32-bit word bus. Software stores a period length in clock cycles. It then sets the run and interrupt-enable bits. From that point the timer counts cycles. At the end of each period it wraps to zero, keeps counting, and requests an interrupt on a single line.

Retiring a request takes two separate bus writes. An acknowledge write drops the request line. An end-of-service write then re-arms the unit. If a period ends while a request is still in service, the event is held as pending. The line is raised again as soon as end-of-service arrives. The data value of either write is ignored.

The unit occupies four word locations starting at the `BASE_ADDR` parameter. Read data is combinational from the address.

Top module: `period_timer`

## Requirements
- R1: The unit decodes four words from `BASE_ADDR`: offset 0x0 is the period register, 0x4 is control, 0x8 is acknowledge and 0xC is end-of-service. Address bits [1:0] are ignored. Any address outside this 16-byte window reads zero, and writes to it change nothing.
- R2: The period register stores and reads back all 32 bits. Control stores `wdata_i[0]` as run and `wdata_i[1]` as interrupt enable. Reading control returns these two bits in the same positions, with every other bit zero.
- R3: Reading the acknowledge or end-of-service location returns zero and leaves `irq_o` unchanged.
- R4: With period P > 0, run set and enable set, starting from count zero, `irq_o` rises exactly P clock edges after the edge that wrote control. Later period ends follow every P edges, because the count wraps to zero in the same cycle it completes a period.
- R5: With run clear, the count holds its value. Setting run again resumes counting from where it stopped.
- R6: With interrupt enable clear, period ends raise no request and leave no pending event behind.
- R7: A write to the acknowledge location drops `irq_o` at the write edge.
- R8: After a request is raised, no new request is raised until an end-of-service write. A period end in that window is held as pending. The pending event raises `irq_o` at the end-of-service write edge.
- R9: An end-of-service write with nothing pending leaves `irq_o` low until the next period end.
- R10: A period of zero stops counting, so no request is raised. Writing a nonzero period then starts counting from the held count.
- R11: Reset clears the period register, control, count, pending flag and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Byte address of the bus access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench times the first request and the following interval edge-exact. A design that wrapped one cycle late would stretch every period to P+1. It lets a period end between acknowledge and end-of-service, and checks that the line stays low until end-of-service and rises exactly at that write. A design that dropped the pending event, or raised it too early, fails there.

It runs with interrupts disabled across several period ends and then enables them. A design that latched those events would fire a stale request. It also pauses mid-period to confirm that run holds the count, and uses a zero period to confirm counting is stopped. Finally, it probes addresses just outside the window and the two strobe locations to catch sloppy decoding and reads that have side effects.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int RUN_BIT  = 0;
  localparam int IEN_BIT  = 1;

  typedef enum logic [IDX_W-1:0] {
    REG_PERIOD = 2'd0,
    REG_CTRL   = 2'd1,
    REG_ACK    = 2'd2,
    REG_EOS    = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import timer_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int OFF_W = IDX_W + 2;

  logic win_hit;
  assign win_hit = (addr_i[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = win_hit && (addr_i[OFF_W-1:2] == IDX_W'(i));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));  // R1
  AST_OUTSIDE_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:OFF_W] != BASE_ADDR[ADDR_W-1:OFF_W]) |-> (sel_o == '0));  // R1
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign en     = run_i && (period_i != '0);
  // >= keeps wrap safe if the period is lowered below the current count
  assign tick_o = en && (cnt_q >= period_i - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (tick_o)  cnt_d = '0;
    else if (en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));  // R5
  AST_ZERO_PERIOD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |=> $stable(cnt_q));  // R10
  AST_WRAP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));  // R4
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ien_i,
  input  logic ack_i,
  input  logic eos_i,
  output logic irq_o
);
  logic irq_q, busy_q, pend_q;
  logic irq_d, busy_d, pend_d;
  logic raise;

  always_comb begin
    busy_d = busy_q && !eos_i;
    pend_d = pend_q;
    raise  = 1'b0;
    if (eos_i && pend_q) begin
      raise  = 1'b1;
      pend_d = 1'b0;
    end
    if (tick_i && ien_i) begin
      if (busy_d || raise) pend_d = 1'b1;
      else                 raise  = 1'b1;
    end
    busy_d = busy_d || raise;
    irq_d  = (irq_q && !ack_i) || raise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      busy_q <= busy_d;
      pend_q <= pend_d;
    end
  end

  assign irq_o = irq_q;

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && busy_q) |=> !irq_o);  // R7
  AST_NO_RAISE_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(eos_i) || !$past(busy_q)));  // R8
  AST_PEND_ONLY_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> busy_q);  // R8
endmodule

// File: rtl/period_timer.sv
module period_timer
  import timer_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] sel;
  logic [CNT_W-1:0]    period_q;
  logic                run_q, ien_q;
  logic                tick;

  tmr_addr_dec #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(addr_i),
    .sel_o (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else if (wr_en_i) begin
      if (sel[REG_PERIOD]) period_q <= wdata_i[CNT_W-1:0];
      if (sel[REG_CTRL]) begin
        run_q <= wdata_i[RUN_BIT];
        ien_q <= wdata_i[IEN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel[REG_PERIOD]) rdata_o = DATA_W'(period_q);
    if (sel[REG_CTRL]) begin
      rdata_o[RUN_BIT] = run_q;
      rdata_o[IEN_BIT] = ien_q;
    end
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .period_i(period_q),
    .tick_o  (tick)
  );

  tmr_irq_ctrl u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .ien_i (ien_q),
    .ack_i (wr_en_i && sel[REG_ACK]),
    .eos_i (wr_en_i && sel[REG_EOS]),
    .irq_o (irq_o)
  );

  AST_STROBE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel[REG_ACK] || sel[REG_EOS]) |-> (rdata_o == '0));  // R3
  AST_CTRL_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel[REG_CTRL]) |=> (run_q == $past(wdata_i[RUN_BIT])));  // R2
endmodule

// File: tb/period_timer_tb_top.sv
module period_timer_tb_top;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  period_timer dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .addr_i (addr),
    .wr_en_i(wr_en),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, BASE + 32'h0,  32'h0,         8'd11}, // R11 period cleared
    '{1'b0, BASE + 32'h4,  32'h0,         8'd11}, // R11 control cleared
    '{1'b1, BASE + 32'h0,  32'hDEAD_BEEF, 8'd2},
    '{1'b0, BASE + 32'h0,  32'hDEAD_BEEF, 8'd2},  // R2
    '{1'b0, BASE + 32'h1,  32'hDEAD_BEEF, 8'd1},  // R1 low bits ignored
    '{1'b1, BASE + 32'h4,  32'hFFFF_FFFC, 8'd2},
    '{1'b0, BASE + 32'h4,  32'h0,         8'd2},  // R2 upper bits dropped
    '{1'b1, BASE + 32'h4,  32'h0000_0002, 8'd2},
    '{1'b0, BASE + 32'h4,  32'h0000_0002, 8'd2},  // R2
    '{1'b0, BASE + 32'h8,  32'h0,         8'd3},  // R3
    '{1'b0, BASE + 32'hC,  32'h0,         8'd3},  // R3
    '{1'b1, BASE + 32'h10, 32'h0000_1234, 8'd1},
    '{1'b0, BASE + 32'h10, 32'h0,         8'd1},  // R1 outside reads zero
    '{1'b1, BASE - 32'h4,  32'h0000_5678, 8'd1},
    '{1'b0, BASE + 32'h0,  32'hDEAD_BEEF, 8'd1},  // R1 outside writes ignored
    '{1'b0, BASE + 32'h4,  32'h0000_0002, 8'd1}   // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    wr_en  = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    do_reset();
    check("R11", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].a, VEC[i].d);
      else begin
        bus_rd(VEC[i].a, rd);
        check($sformatf("R%0d", VEC[i].req), rd, VEC[i].d);
      end
    end
    check("R1", {31'b0, irq}, 32'h0);

    // R4 R7 R9 R3 R8: period 5
    do_reset();
    bus_wr(BASE + 32'h0, 32'd5);
    bus_wr(BASE + 32'h4, 32'd3);          // edge E0
    idle(4);
    check("R4 early", {31'b0, irq}, 32'h0);
    idle(1);
    check("R4 first", {31'b0, irq}, 32'h1);
    bus_rd(BASE + 32'h8, rd);
    check("R3 ack read", rd, 32'h0);
    bus_rd(BASE + 32'hC, rd);
    check("R3 eos read", rd, 32'h0);
    check("R3 irq kept", {31'b0, irq}, 32'h1);
    bus_wr(BASE + 32'h8, 32'hFFFF_FFFF);  // E0+6
    check("R7", {31'b0, irq}, 32'h0);
    bus_wr(BASE + 32'hC, 32'h0);          // E0+7
    check("R9", {31'b0, irq}, 32'h0);
    idle(2);
    check("R4 interval early", {31'b0, irq}, 32'h0);
    idle(1);
    check("R4 interval", {31'b0, irq}, 32'h1);
    bus_wr(BASE + 32'h8, 32'h0);          // E0+11
    idle(5);                              // period end at E0+15 held
    check("R8 held", {31'b0, irq}, 32'h0);
    bus_wr(BASE + 32'hC, 32'h0);          // E0+17
    check("R8 released", {31'b0, irq}, 32'h1);
    bus_wr(BASE + 32'h8, 32'h0);          // E0+18
    bus_wr(BASE + 32'hC, 32'h0);          // E0+19
    check("R9 no pending", {31'b0, irq}, 32'h0);
    idle(1);
    check("R4 next", {31'b0, irq}, 32'h1);

    // R5: pause mid-period
    do_reset();
    bus_wr(BASE + 32'h0, 32'd10);
    bus_wr(BASE + 32'h4, 32'd3);          // E0
    idle(3);
    bus_wr(BASE + 32'h4, 32'd2);          // E0+4, count 4
    idle(20);
    check("R5 paused", {31'b0, irq}, 32'h0);
    bus_wr(BASE + 32'h4, 32'd3);
    idle(5);
    check("R5 resume early", {31'b0, irq}, 32'h0);
    idle(1);
    check("R5 resume", {31'b0, irq}, 32'h1);

    // R6: enable clear
    do_reset();
    bus_wr(BASE + 32'h0, 32'd4);
    bus_wr(BASE + 32'h4, 32'd1);          // E0
    idle(10);
    check("R6 disabled", {31'b0, irq}, 32'h0);
    bus_wr(BASE + 32'h4, 32'd3);          // E0+11
    check("R6 no stale", {31'b0, irq}, 32'h0);
    idle(1);
    check("R6 enabled", {31'b0, irq}, 32'h1);

    // R10: zero period
    do_reset();
    bus_wr(BASE + 32'h4, 32'd3);
    idle(50);
    check("R10 zero", {31'b0, irq}, 32'h0);
    bus_wr(BASE + 32'h0, 32'd3);          // E0
    idle(2);
    check("R10 start early", {31'b0, irq}, 32'h0);
    idle(1);
    check("R10 start", {31'b0, irq}, 32'h1);

    // R11: reset mid-request
    do_reset();
    check("R11 irq", {31'b0, irq}, 32'h0);
    bus_rd(BASE + 32'h0, rd);
    check("R11 period", rd, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule